// File: doc/BRIEF.md
# Host Bridge Register Window Decoder

This block sits behind the CPU side of a PCI host bridge and decodes a 16 MB register aperture. Each CPU access names an offset, a size of one to four bytes, a read or write strobe and little-endian write data. The decoder sends each access to one of four places. Offsets below 0xC00000 go to an I/O window and take precedence over every other decode. The configuration address register sits at 0xC00CF8. A four-byte configuration data port covers 0xE00CFC to 0xE00CFF. An interrupt-acknowledge read port sits at 0xF00000.

Request outputs to the I/O window, the configuration engine and the interrupt controller are combinational and valid in the access cycle. Read data comes back on a registered response one cycle later. Any access that no target claims returns all ones on a read, is dropped on a write, and raises a one-cycle error pulse. The PCI bus protocol and the interrupt controller stay outside the block.

Top module: `hbr_window_dec`

## Requirements
- R1: An access whose offset is below 0xC00000 asserts `ioReq` and no other request. It passes offset, size and write data through unchanged, with `ioWr` equal to the write strobe. Read data is `ioRdata` with the bytes above the access size cleared.
- R2: A write at exactly 0xC00CF8 updates the byte lanes 0 to `cpuSize` of the configuration address register (lane 0 = bits 7:0). Bits 1:0 always read as zero, and the register resets to zero. A read at that offset returns the register with bytes above the size cleared.
- R3: Offsets 0xE00CFC to 0xE00CFF form the data port. If bit 31 of the configuration address register is set, an access there asserts `cfgReq` with `cfgByteOff` = offset bits 1:0. `cfgBe` bit i is set for each lane i from the offset up to offset+size, cut off at lane 3. Write data is moved up by 8×offset bits.
- R4: A data-port read with bit 31 set returns `cfgRdata` moved down by 8×offset bits, with bytes above the size cleared.
- R5: With bit 31 clear, a data-port access makes no request. A read returns 0xFFFFFFFF and a write is dropped. Neither raises the error pulse.
- R6: A read at 0xF00000 asserts `iackReq` for that cycle. It returns `iackVector` zero-extended and cleared above the size.
- R7: Any other access is unclaimed. This includes a write at 0xF00000 and non-exact offsets near the address register. A read returns 0xFFFFFFFF, a write makes no request, and `errPulse` is high for exactly the next cycle.
- R8: `cpuRvalid` is high in the cycle after each read access and low after writes and idle cycles.
- R9: A cycle with both `cpuRd` and `cpuWr` high is no access: no request, no state change, no response, no error.
- R10: `cpuSize` value n means n+1 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 24 | Offset within the aperture |
| cpuSize | input | 2 | Access size minus one |
| cpuRd | input | 1 | Read strobe |
| cpuWr | input | 1 | Write strobe |
| cpuWdata | input | 32 | Write data, byte 0 in bits 7:0 |
| cpuRdata | output | 32 | Read data, registered |
| cpuRvalid | output | 1 | Read data valid |
| errPulse | output | 1 | Unclaimed-access pulse |
| ioReq | output | 1 | I/O window request |
| ioWr | output | 1 | I/O window write |
| ioAddr | output | 24 | I/O window offset |
| ioSize | output | 2 | I/O access size minus one |
| ioWdata | output | 32 | I/O write data |
| ioRdata | input | 32 | I/O read data |
| cfgReq | output | 1 | Configuration data request |
| cfgWr | output | 1 | Configuration data write |
| cfgAddr | output | 32 | Configuration address register |
| cfgByteOff | output | 2 | Byte offset within the data port |
| cfgBe | output | 4 | Configuration byte enables |
| cfgWdata | output | 32 | Lane-aligned configuration write data |
| cfgRdata | input | 32 | Configuration read data |
| iackReq | output | 1 | Interrupt-acknowledge request |
| iackVector | input | 8 | Vector from the interrupt controller |

## Verification
On every cycle the assertions check these properties:
- At most one request fires at a time.
- A configuration request only appears with the enable bit set, and it always carries an enable at its own byte offset.
- The address register's low bits stay zero.
- Double-strobe cycles make no request.
- Each read gets a response one cycle later.
- An error on a read returns all ones.

The actual lane arithmetic needs the bench's scenarios: merged register contents, shifted data, truncated enables at offset 3, and the zero-extended vector. So does the disabled port's silence and the one-cycle width of the error pulse.

// File: rtl/hbw_pkg.sv
package hbw_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef struct packed {
    logic isRd;
    logic isWr;
    logic ioSel;
    logic cfgAddrRd;
    logic cfgAddrWr;
    logic cfgDataGo;
    logic cfgDataOnes;
    logic iackRd;
    logic miss;
  } strobe_t;

  function automatic logic [LANES-1:0] laneBase(input logic [1:0] sz);
    logic [LANES-1:0] r;
    for (int i = 0; i < LANES; i++) r[i] = (i <= int'(sz));
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] laneMask(input logic [LANES-1:0] l);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < LANES; i++) m[8*i +: 8] = {8{l[i]}};
    return m;
  endfunction
endpackage

// File: rtl/hbw_ctrl.sv
module hbw_ctrl
  import hbw_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] IO_TOP = 24'hC00000,
  parameter logic [ADDR_W-1:0] CFG_ADDR_OFS = 24'hC00CF8,
  parameter logic [ADDR_W-1:0] CFG_DATA_OFS = 24'hE00CFC,
  parameter logic [ADDR_W-1:0] IACK_OFS = 24'hF00000
) (
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic              cfgEnable,
  output strobe_t           stb
);
  logic rdOnly, wrOnly, inIo, hitCa, hitCd, hitIa;

  always_comb begin
    rdOnly = cpuRd & ~cpuWr;
    wrOnly = cpuWr & ~cpuRd;
    inIo   = cpuAddr < IO_TOP;
    hitCa  = cpuAddr == CFG_ADDR_OFS;
    hitCd  = cpuAddr[ADDR_W-1:2] == CFG_DATA_OFS[ADDR_W-1:2];
    hitIa  = cpuAddr == IACK_OFS;
    stb = '0;
    stb.isRd = rdOnly;
    stb.isWr = wrOnly;
    if (rdOnly || wrOnly) begin
      if (inIo) begin
        stb.ioSel = 1'b1;
      end else if (hitCa) begin
        stb.cfgAddrRd = rdOnly;
        stb.cfgAddrWr = wrOnly;
      end else if (hitCd) begin
        if (cfgEnable) stb.cfgDataGo = 1'b1;
        else           stb.cfgDataOnes = rdOnly;
      end else if (hitIa && rdOnly) begin
        stb.iackRd = 1'b1;
      end else begin
        stb.miss = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hbw_dpath.sv
module hbw_dpath
  import hbw_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [1:0]        laneOff,
  input  logic [1:0]        cpuSize,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] ioRdata,
  input  logic [DATA_W-1:0] cfgRdata,
  input  logic [VEC_W-1:0]  iackVector,
  output logic              cfgEnable,
  output logic [DATA_W-1:0] cfgAddr,
  output logic [LANES-1:0]  cfgBe,
  output logic [DATA_W-1:0] cfgWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuRvalid,
  output logic              errPulse
);
  localparam logic [DATA_W-1:0] LOW_CLR = ~DATA_W'(3);

  logic [LANES-1:0]  base;
  logic [DATA_W-1:0] sizeMask, caNext, rdNext, cfgRdShift, cfgAddrQ;

  assign base     = laneBase(cpuSize);
  assign sizeMask = laneMask(base);

  always_comb begin
    for (int i = 0; i < LANES; i++)
      cfgBe[i] = (i >= int'(laneOff)) && ((i - int'(laneOff)) <= int'(cpuSize));
  end

  assign cfgWdata   = cpuWdata << {laneOff, 3'b000};
  assign cfgRdShift = cfgRdata >> {laneOff, 3'b000};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign caNext[8*g +: 8] = (stb.cfgAddrWr && base[g]) ? cpuWdata[8*g +: 8]
                                                         : cfgAddrQ[8*g +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) cfgAddrQ <= '0;
    else       cfgAddrQ <= caNext & LOW_CLR;
  end

  assign cfgAddr   = cfgAddrQ;
  assign cfgEnable = cfgAddrQ[DATA_W-1];

  always_comb begin
    rdNext = '1;
    if (stb.ioSel)          rdNext = ioRdata & sizeMask;
    else if (stb.cfgAddrRd) rdNext = cfgAddrQ & sizeMask;
    else if (stb.cfgDataGo) rdNext = cfgRdShift & sizeMask;
    else if (stb.iackRd)    rdNext = DATA_W'(iackVector) & sizeMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuRdata  <= '0;
      cpuRvalid <= 1'b0;
      errPulse  <= 1'b0;
    end else begin
      cpuRvalid <= stb.isRd;
      errPulse  <= stb.miss;
      if (stb.isRd) cpuRdata <= rdNext;
    end
  end
endmodule

// File: rtl/hbr_window_dec.sv
module hbr_window_dec
  import hbw_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int VEC_W  = 8,
  parameter logic [ADDR_W-1:0] IO_TOP = 24'hC00000,
  parameter logic [ADDR_W-1:0] CFG_ADDR_OFS = 24'hC00CF8,
  parameter logic [ADDR_W-1:0] CFG_DATA_OFS = 24'hE00CFC,
  parameter logic [ADDR_W-1:0] IACK_OFS = 24'hF00000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [1:0]        cpuSize,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic [31:0]       cpuWdata,
  output logic [31:0]       cpuRdata,
  output logic              cpuRvalid,
  output logic              errPulse,
  output logic              ioReq,
  output logic              ioWr,
  output logic [ADDR_W-1:0] ioAddr,
  output logic [1:0]        ioSize,
  output logic [31:0]       ioWdata,
  input  logic [31:0]       ioRdata,
  output logic              cfgReq,
  output logic              cfgWr,
  output logic [31:0]       cfgAddr,
  output logic [1:0]        cfgByteOff,
  output logic [3:0]        cfgBe,
  output logic [31:0]       cfgWdata,
  input  logic [31:0]       cfgRdata,
  output logic              iackReq,
  input  logic [VEC_W-1:0]  iackVector
);
  strobe_t stb;
  logic    cfgEnable;

  hbw_ctrl #(
    .ADDR_W(ADDR_W), .IO_TOP(IO_TOP), .CFG_ADDR_OFS(CFG_ADDR_OFS),
    .CFG_DATA_OFS(CFG_DATA_OFS), .IACK_OFS(IACK_OFS)
  ) u_ctrl (
    .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .cfgEnable(cfgEnable), .stb(stb)
  );

  hbw_dpath #(.VEC_W(VEC_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .laneOff(cpuAddr[1:0]),
    .cpuSize(cpuSize), .cpuWdata(cpuWdata), .ioRdata(ioRdata),
    .cfgRdata(cfgRdata), .iackVector(iackVector), .cfgEnable(cfgEnable),
    .cfgAddr(cfgAddr), .cfgBe(cfgBe), .cfgWdata(cfgWdata),
    .cpuRdata(cpuRdata), .cpuRvalid(cpuRvalid), .errPulse(errPulse)
  );

  assign ioReq      = stb.ioSel;
  assign ioWr       = stb.ioSel & stb.isWr;
  assign ioAddr     = cpuAddr;
  assign ioSize     = cpuSize;
  assign ioWdata    = cpuWdata;
  assign cfgReq     = stb.cfgDataGo;
  assign cfgWr      = stb.cfgDataGo & stb.isWr;
  assign cfgByteOff = cpuAddr[1:0];
  assign iackReq    = stb.iackRd;
endmodule

// File: rtl/hbw_chk.sv
module hbw_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cpuRd,
  input logic        cpuWr,
  input logic [31:0] cpuRdata,
  input logic        cpuRvalid,
  input logic        errPulse,
  input logic        ioReq,
  input logic        cfgReq,
  input logic [31:0] cfgAddr,
  input logic [1:0]  cfgByteOff,
  input logic [3:0]  cfgBe,
  input logic        iackReq
);
  a_r1_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ioReq, cfgReq, iackReq}));

  a_r5_cfg_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq |-> cfgAddr[31]);

  a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    cfgAddr[1:0] == 2'b00);

  a_r3_be_at_offset: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq |-> cfgBe[cfgByteOff]);

  a_r8_read_answered: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && !cpuWr) |=> cpuRvalid);

  a_r8_no_stray_valid: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuRd && !cpuWr) |=> !cpuRvalid);

  a_r7_miss_reads_ones: assert property (@(posedge clk) disable iff (!rstN)
    (errPulse && cpuRvalid) |-> cpuRdata == 32'hFFFF_FFFF);

  a_r9_double_strobe_idle: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && cpuWr) |-> !ioReq && !cfgReq && !iackReq);
endmodule

bind hbr_window_dec hbw_chk u_chk (
  .clk(clk), .rstN(rstN), .cpuRd(cpuRd), .cpuWr(cpuWr),
  .cpuRdata(cpuRdata), .cpuRvalid(cpuRvalid), .errPulse(errPulse),
  .ioReq(ioReq), .cfgReq(cfgReq), .cfgAddr(cfgAddr),
  .cfgByteOff(cfgByteOff), .cfgBe(cfgBe), .iackReq(iackReq)
);

// File: tb/sim_hbr_window_dec.sv
module sim_hbr_window_dec;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] cpuAddr = '0;
  logic [1:0]  cpuSize = '0;
  logic        cpuRd = 1'b0, cpuWr = 1'b0;
  logic [31:0] cpuWdata = '0;
  logic [31:0] cpuRdata;
  logic        cpuRvalid, errPulse, ioReq, ioWr, cfgReq, cfgWr, iackReq;
  logic [23:0] ioAddr;
  logic [1:0]  ioSize, cfgByteOff;
  logic [31:0] ioWdata, cfgAddr, cfgWdata;
  logic [3:0]  cfgBe;
  logic [31:0] ioRdata = 32'hA1B2C3D4;
  logic [31:0] cfgRdata = 32'h44332211;
  logic [7:0]  iackVector = 8'h5A;

  int nChk = 0, nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hbr_window_dec u0 (.*);

  typedef struct packed {
    logic [23:0] a; logic [1:0] sz; logic rd; logic wr; logic [31:0] wd;
    logic eIo; logic eCfg; logic eIack; logic eErr;
    logic [3:0] eBe; logic [31:0] eWd; logic [31:0] eRd; logic [3:0] req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    '{24'h000100, 2'd3, 1, 0, 32'h0,        1,0,0,0, 4'h0, 32'h0,        32'hA1B2C3D4, 4'd1}, // R1
    '{24'h000102, 2'd0, 1, 0, 32'h0,        1,0,0,0, 4'h0, 32'h0,        32'h000000D4, 4'd1}, // R1 R10
    '{24'hBFFFFF, 2'd0, 0, 1, 32'h77,       1,0,0,0, 4'h0, 32'h0,        32'h0,        4'd1}, // R1
    '{24'hC00CF8, 2'd3, 1, 0, 32'h0,        0,0,0,0, 4'h0, 32'h0,        32'h00000000, 4'd2}, // R2
    '{24'hE00CFC, 2'd3, 1, 0, 32'h0,        0,0,0,0, 4'h0, 32'h0,        32'hFFFFFFFF, 4'd5}, // R5
    '{24'hE00CFC, 2'd3, 0, 1, 32'h12345678, 0,0,0,0, 4'h0, 32'h0,        32'h0,        4'd5}, // R5
    '{24'hC00CF8, 2'd3, 0, 1, 32'h80000013, 0,0,0,0, 4'h0, 32'h0,        32'h0,        4'd2}, // R2
    '{24'hC00CF8, 2'd3, 1, 0, 32'h0,        0,0,0,0, 4'h0, 32'h0,        32'h80000010, 4'd2}, // R2
    '{24'hE00CFE, 2'd1, 1, 0, 32'h0,        0,1,0,0, 4'hC, 32'h0,        32'h00004433, 4'd4}, // R4
    '{24'hE00CFD, 2'd0, 0, 1, 32'hEE,       0,1,0,0, 4'h2, 32'h0000EE00, 32'h0,        4'd3}, // R3
    '{24'hE00CFF, 2'd3, 1, 0, 32'h0,        0,1,0,0, 4'h8, 32'h0,        32'h00000044, 4'd3}, // R3
    '{24'hE00CFC, 2'd3, 0, 1, 32'hCAFEF00D, 0,1,0,0, 4'hF, 32'hCAFEF00D, 32'h0,        4'd3}, // R3
    '{24'hF00000, 2'd0, 1, 0, 32'h0,        0,0,1,0, 4'h0, 32'h0,        32'h0000005A, 4'd6}, // R6
    '{24'hF00000, 2'd3, 1, 0, 32'h0,        0,0,1,0, 4'h0, 32'h0,        32'h0000005A, 4'd6}, // R6
    '{24'hD00000, 2'd3, 1, 0, 32'h0,        0,0,0,1, 4'h0, 32'h0,        32'hFFFFFFFF, 4'd7}, // R7
    '{24'hF00000, 2'd0, 0, 1, 32'h5,        0,0,0,1, 4'h0, 32'h0,        32'h0,        4'd7}, // R7
    '{24'hC00CFC, 2'd1, 1, 0, 32'h0,        0,0,0,1, 4'h0, 32'h0,        32'hFFFFFFFF, 4'd7}, // R7
    '{24'hE00D00, 2'd0, 0, 1, 32'h1,        0,0,0,1, 4'h0, 32'h0,        32'h0,        4'd7}, // R7
    '{24'hC00CF8, 2'd1, 0, 1, 32'h0000ABCD, 0,0,0,0, 4'h0, 32'h0,        32'h0,        4'd2}, // R2
    '{24'hC00CF8, 2'd3, 1, 0, 32'h0,        0,0,0,0, 4'h0, 32'h0,        32'h8000ABCC, 4'd2}, // R2
    '{24'hC00CF8, 2'd3, 0, 1, 32'h0,        0,0,0,0, 4'h0, 32'h0,        32'h0,        4'd5}, // R5
    '{24'hE00CFD, 2'd0, 1, 0, 32'h0,        0,0,0,0, 4'h0, 32'h0,        32'hFFFFFFFF, 4'd5}  // R5
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cpuRd = 1'b0; cpuWr = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 R8 R7: reset state
    chk(cfgAddr == 32'h0, "R2 reset addr", cfgAddr, 32'h0);
    chk(!cpuRvalid && !errPulse, "R8 reset outputs", {cpuRvalid, errPulse}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      automatic vec_t v = TBL[i];
      automatic string r = $sformatf("R%0d row%0d", v.req, i);
      cpuAddr = v.a; cpuSize = v.sz; cpuRd = v.rd; cpuWr = v.wr; cpuWdata = v.wd;
      #1;
      chk({ioReq, cfgReq, iackReq} == {v.eIo, v.eCfg, v.eIack}, r,
          {ioReq, cfgReq, iackReq}, {v.eIo, v.eCfg, v.eIack});
      if (v.eIo)
        chk(ioAddr == v.a && ioWr == v.wr && ioSize == v.sz, r, ioAddr, v.a);
      if (v.eCfg) begin
        chk(cfgBe == v.eBe && cfgByteOff == v.a[1:0] && cfgWr == v.wr, r,
            cfgBe, v.eBe);
        if (v.wr) chk(cfgWdata == v.eWd, r, cfgWdata, v.eWd);
      end
      @(negedge clk);
      idle();
      chk(cpuRvalid == v.rd, r, cpuRvalid, v.rd);
      chk(errPulse == v.eErr, r, errPulse, v.eErr);
      if (v.rd) chk(cpuRdata == v.eRd, r, cpuRdata, v.eRd);
    end

    // R7: error pulse is one cycle wide
    cpuAddr = 24'hD00004; cpuSize = 2'd0; cpuWr = 1'b1;
    @(negedge clk); idle();
    chk(errPulse, "R7 pulse", errPulse, 1);
    @(negedge clk);
    chk(!errPulse, "R7 pulse width", errPulse, 0);

    // R9: both strobes at the address register and the I/O window
    cpuAddr = 24'hC00CF8; cpuSize = 2'd3; cpuWdata = 32'h8000_0100;
    cpuRd = 1'b1; cpuWr = 1'b1; #1;
    chk(!ioReq && !cfgReq && !iackReq, "R9 no request", {ioReq, cfgReq, iackReq}, 0);
    @(negedge clk); idle();
    chk(!cpuRvalid && !errPulse && cfgAddr == 32'h0, "R9 no effect", cfgAddr, 32'h0);
    cpuAddr = 24'h000010; cpuRd = 1'b1; cpuWr = 1'b1; #1;
    chk(!ioReq, "R9 io blocked", ioReq, 0);
    @(negedge clk); idle();

    // R2: reset mid-run clears the address register
    cpuAddr = 24'hC00CF8; cpuSize = 2'd3; cpuWdata = 32'h8000_0044; cpuWr = 1'b1;
    @(negedge clk); idle();
    chk(cfgAddr == 32'h8000_0044, "R2 write", cfgAddr, 32'h8000_0044);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    chk(cfgAddr == 32'h0, "R2 re-reset", cfgAddr, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule